// File: doc/BRIEF.md
# Return-Address Stack and Call/Return Sequencer

This block keeps the program counter of a small processor core together with a hardware stack of return addresses. A decoder upstream hands it one command per cycle: step, software push, software pop, relative call, plain return, interrupt return, literal return and software reset. The block moves the program counter, pushes and pops return addresses, and signals the core when the working register, the status register and the bank-select register must be reloaded.

When an interrupt is taken, the interrupt logic pulses a capture input. The block then saves the working, status and bank-select values into shadow copies and remembers the priority level that was entered. A later return with its fast flag set drives those shadow values out with a write strobe. An interrupt return also pulses the global enable output that matches the saved priority. Calls and all returns occupy two cycles. During the second cycle the block reports itself busy and discards any command offered to it.

Top module: `retstk_seq`

## Requirements
- R1: After the synchronous active-low reset, the program counter, top-of-stack value, depth, both sticky flags, busy and every strobe output read zero.
- R2: A push (cmd_i=1) stores PC+2 as the new top, keeps the old top one level below it, advances the PC by 2 and takes one cycle.
- R3: A pop (cmd_i=2) discards the top so that the entry below becomes the top, advances the PC by 2 and takes one cycle.
- R4: A relative call (cmd_i=3) with 11-bit two's-complement offset n pushes PC+2, loads the PC with PC+2+2n modulo 2^PC_W, and holds busy_o high for the one cycle that follows.
- R5: A plain return (cmd_i=4) loads the PC with the top entry, pops it and holds busy_o for one cycle. With fast_i=1 it pulses w_wr_o and ctx_wr_o for one cycle, carrying the shadow W, STATUS and BSR values on w_data_o, status_o and bsr_o. With fast_i=0 no strobe appears, and the data outputs read zero whenever their strobe is low.
- R6: An interrupt return (cmd_i=5) behaves as a plain return and also pulses gieh_set_o if the last capture was high priority, or giel_set_o otherwise. The two pulses never occur together.
- R7: A literal return (cmd_i=6) loads the PC from the top entry, pops it, takes two cycles and pulses w_wr_o with w_data_o equal to lit_i. It never pulses ctx_wr_o.
- R8: A command offered while busy_o is high is ignored: the PC, stack and strobes show no effect from it.
- R9: A push or call on a full stack (DEPTH entries) stores nothing, leaves the depth at DEPTH and the top unchanged, and sets the sticky ovf_o.
- R10: A pop or return on an empty stack sets the sticky unf_o and uses zero as the popped value, so a return loads PC=0.
- R11: A software reset (cmd_i=7) returns the PC, the stack, both flags and the shadow registers to their reset values in one cycle.
- R12: A step (cmd_i=0) advances the PC by 2 and leaves the stack unchanged.
- R13: A pulse on irq_take_i captures w_i, status_i, bsr_i and irq_hi_i into the shadow registers. A restore in the same cycle still sends out the values captured before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_vld_i | input | 1 | A command is offered this cycle |
| cmd_i | input | 3 | Command code: 0 step, 1 push, 2 pop, 3 call, 4 return, 5 interrupt return, 6 literal return, 7 reset |
| ofs_i | input | OFS_W | Signed word offset for a relative call |
| lit_i | input | DATA_W | Literal for a literal return |
| fast_i | input | 1 | Restore the shadow registers on a return |
| irq_take_i | input | 1 | Interrupt entry: capture the shadow registers |
| irq_hi_i | input | 1 | The entered interrupt is high priority |
| w_i | input | DATA_W | Current working register |
| status_i | input | DATA_W | Current status register |
| bsr_i | input | BSR_W | Current bank-select register |
| pc_o | output | PC_W | Program counter |
| tos_o | output | PC_W | Top-of-stack value, zero when empty |
| depth_o | output | clog2(DEPTH+1) | Number of stored entries |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| busy_o | output | 1 | Second cycle of a two-cycle command |
| w_wr_o | output | 1 | Write strobe for the working register |
| w_data_o | output | DATA_W | Value to write into the working register |
| ctx_wr_o | output | 1 | Write strobe for STATUS and BSR |
| status_o | output | DATA_W | Restored STATUS value |
| bsr_o | output | BSR_W | Restored BSR value |
| gieh_set_o | output | 1 | Set the high-priority global interrupt enable |
| giel_set_o | output | 1 | Set the low-priority global interrupt enable |

## Verification
The bench builds the block with DEPTH=4 and leaves PC_W at 21 and OFS_W at 11. The small stack lets five pushes show the full-stack rule within a few cycles. Underflow is reached right after a software reset. The full PC width keeps the sign extension of negative call offsets and the modulo wrap of the call target in view. The shadow capture is placed in the same cycle as a fast return to expose the ordering rule of R13.

// File: rtl/retstk_pkg.sv
// Shared command encoding for the return-stack sequencer.
// Assumes the upstream decoder delivers these 3-bit codes.
package retstk_pkg;
    typedef enum logic [2:0] {
        CMD_STEP   = 3'd0,
        CMD_PUSH   = 3'd1,
        CMD_POP    = 3'd2,
        CMD_CALL   = 3'd3,
        CMD_RET    = 3'd4,
        CMD_RETI   = 3'd5,
        CMD_RETLIT = 3'd6,
        CMD_SWRST  = 3'd7
    } cmd_e;
endpackage

// File: rtl/retstk_mem.sv
// Return-address storage: a LIFO array with an entry count and sticky flags.
// Assumes push and pop requests are mutually exclusive, and that clr
// (software reset) never arrives together with either of them.
module retstk_mem #(
    parameter int PC_W  = 21,
    parameter int DEPTH = 31
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_req,
    input  logic                       pop_req,
    input  logic                       clr_req,
    input  logic [PC_W-1:0]            push_val,
    output logic [PC_W-1:0]            tos,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       ovf,
    output logic                       unf
);
    localparam int PTR_W = $clog2(DEPTH+1);

    logic [PC_W-1:0] stk [DEPTH];
    logic            full;
    logic            empty;

    assign full  = (cnt == PTR_W'(DEPTH));
    assign empty = (cnt == '0);

    // Read out the top entry, or zero when nothing is stored.
    always_comb begin
        tos = '0;
        if (!empty) tos = stk[cnt - PTR_W'(1)];
    end

    // Write a pushed address into the next free slot; a full stack drops it.
    always_ff @(posedge clk) begin
        if (push_req && !full) stk[cnt] <= push_val;
    end

    // Track the entry count and latch the overflow and underflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (push_req) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + PTR_W'(1);
        end else if (pop_req) begin
            if (empty) unf <= 1'b1;
            else       cnt <= cnt - PTR_W'(1);
        end
    end

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> (ovf && cnt == PTR_W'(DEPTH) && $stable(tos)));

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> (unf && tos == '0));

    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full) |=> (tos == $past(push_val)));
endmodule

// File: rtl/retstk_ctrl.sv
// Command sequencer: accepts one command per cycle, owns the program
// counter, and inserts a dead second cycle after calls and returns.
// Assumes tos reflects the stack top before this cycle's pop.
module retstk_ctrl
    import retstk_pkg::*;
#(
    parameter int PC_W  = 21,
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [2:0]       cmd,
    input  logic [OFS_W-1:0] ofs,
    input  logic [PC_W-1:0]  tos,
    output logic [PC_W-1:0]  pc,
    output logic             busy,
    output logic             push_req,
    output logic             pop_req,
    output logic             clr_req,
    output logic [PC_W-1:0]  push_val,
    output logic             ret_req,
    output logic             reti_req,
    output logic             retlit_req
);
    localparam int EXT_W = PC_W - OFS_W - 1;

    cmd_e            op;
    logic            accept;
    logic            is_ret;
    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] rel_step;

    assign op       = cmd_e'(cmd);
    assign accept   = cmd_vld && !busy;
    assign pc_seq   = pc + PC_W'(2);
    assign rel_step = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
    assign push_val = pc_seq;
    assign is_ret   = (op == CMD_RET) || (op == CMD_RETI) || (op == CMD_RETLIT);

    // Decode the accepted command into stack and context requests.
    always_comb begin
        push_req   = accept && (op == CMD_PUSH || op == CMD_CALL);
        pop_req    = accept && (op == CMD_POP || is_ret);
        clr_req    = accept && (op == CMD_SWRST);
        ret_req    = accept && (op == CMD_RET || op == CMD_RETI);
        reti_req   = accept && (op == CMD_RETI);
        retlit_req = accept && (op == CMD_RETLIT);
    end

    // Update the program counter and the two-cycle busy marker.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            pc   <= '0;
            busy <= 1'b0;
        end else if (busy) begin
            busy <= 1'b0;
        end else if (accept) begin
            unique case (op)
                CMD_CALL: begin
                    pc   <= pc_seq + rel_step;
                    busy <= 1'b1;
                end
                CMD_RET, CMD_RETI, CMD_RETLIT: begin
                    pc   <= tos;
                    busy <= 1'b1;
                end
                default: pc <= pc_seq;
            endcase
        end
    end

    p_busy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pc));

    p_ret_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_ret) |=> (pc == $past(tos) && busy));

    p_call_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == CMD_CALL) |=> busy);

    p_swrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (pc == '0 && !busy));
endmodule

// File: rtl/retstk_shadow.sv
// Context unit: captures the shadow copies on interrupt entry and emits
// registered restore, literal-write and enable-set pulses on returns.
// Assumes the request inputs are single-cycle and mutually consistent.
module retstk_shadow #(
    parameter int DATA_W = 8,
    parameter int BSR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic              irq_take,
    input  logic              irq_hi,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [BSR_W-1:0]  bsr_in,
    input  logic              ret_req,
    input  logic              reti_req,
    input  logic              retlit_req,
    input  logic              fast,
    input  logic [DATA_W-1:0] lit,
    output logic              w_wr,
    output logic [DATA_W-1:0] w_data,
    output logic              ctx_wr,
    output logic [DATA_W-1:0] status_out,
    output logic [BSR_W-1:0]  bsr_out,
    output logic              gieh_set,
    output logic              giel_set
);
    logic [DATA_W-1:0] sh_w;
    logic [DATA_W-1:0] sh_st;
    logic [BSR_W-1:0]  sh_bsr;
    logic              sh_hi;
    logic              restore;

    assign restore = ret_req && fast;

    // Hold the shadow copies; a software reset takes precedence over capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            sh_w   <= '0;
            sh_st  <= '0;
            sh_bsr <= '0;
            sh_hi  <= 1'b0;
        end else if (irq_take) begin
            sh_w   <= w_in;
            sh_st  <= status_in;
            sh_bsr <= bsr_in;
            sh_hi  <= irq_hi;
        end
    end

    // Drive one-cycle strobes; data outputs are zero while strobes are low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_wr       <= 1'b0;
            w_data     <= '0;
            ctx_wr     <= 1'b0;
            status_out <= '0;
            bsr_out    <= '0;
            gieh_set   <= 1'b0;
            giel_set   <= 1'b0;
        end else begin
            w_wr       <= retlit_req || restore;
            w_data     <= retlit_req ? lit : (restore ? sh_w : '0);
            ctx_wr     <= restore;
            status_out <= restore ? sh_st : '0;
            bsr_out    <= restore ? sh_bsr : '0;
            gieh_set   <= reti_req && sh_hi;
            giel_set   <= reti_req && !sh_hi;
        end
    end

    p_gie_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gieh_set && giel_set));

    p_lit_no_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retlit_req |=> (w_wr && !ctx_wr && w_data == $past(lit)));

    p_capture_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !clr_req) |=> (sh_w == $past(w_in) && sh_hi == $past(irq_hi)));
endmodule

// File: rtl/retstk_seq.sv
// Top level of the return-address stack and call/return sequencer.
// Connects the command sequencer, the address stack and the context unit.
// Assumes at most one command per cycle and a synchronous active-low reset.
module retstk_seq #(
    parameter int PC_W   = 21,
    parameter int DEPTH  = 31,
    parameter int OFS_W  = 11,
    parameter int DATA_W = 8,
    parameter int BSR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_vld_i,
    input  logic [2:0]                 cmd_i,
    input  logic [OFS_W-1:0]           ofs_i,
    input  logic [DATA_W-1:0]          lit_i,
    input  logic                       fast_i,
    input  logic                       irq_take_i,
    input  logic                       irq_hi_i,
    input  logic [DATA_W-1:0]          w_i,
    input  logic [DATA_W-1:0]          status_i,
    input  logic [BSR_W-1:0]           bsr_i,
    output logic [PC_W-1:0]            pc_o,
    output logic [PC_W-1:0]            tos_o,
    output logic [$clog2(DEPTH+1)-1:0] depth_o,
    output logic                       ovf_o,
    output logic                       unf_o,
    output logic                       busy_o,
    output logic                       w_wr_o,
    output logic [DATA_W-1:0]          w_data_o,
    output logic                       ctx_wr_o,
    output logic [DATA_W-1:0]          status_o,
    output logic [BSR_W-1:0]           bsr_o,
    output logic                       gieh_set_o,
    output logic                       giel_set_o
);
    logic            push_req;
    logic            pop_req;
    logic            clr_req;
    logic            ret_req;
    logic            reti_req;
    logic            retlit_req;
    logic [PC_W-1:0] push_val;

    retstk_ctrl #(.PC_W(PC_W), .OFS_W(OFS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_vld    (cmd_vld_i),
        .cmd        (cmd_i),
        .ofs        (ofs_i),
        .tos        (tos_o),
        .pc         (pc_o),
        .busy       (busy_o),
        .push_req   (push_req),
        .pop_req    (pop_req),
        .clr_req    (clr_req),
        .push_val   (push_val),
        .ret_req    (ret_req),
        .reti_req   (reti_req),
        .retlit_req (retlit_req)
    );

    retstk_mem #(.PC_W(PC_W), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .clr_req  (clr_req),
        .push_val (push_val),
        .tos      (tos_o),
        .cnt      (depth_o),
        .ovf      (ovf_o),
        .unf      (unf_o)
    );

    retstk_shadow #(.DATA_W(DATA_W), .BSR_W(BSR_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_req    (clr_req),
        .irq_take   (irq_take_i),
        .irq_hi     (irq_hi_i),
        .w_in       (w_i),
        .status_in  (status_i),
        .bsr_in     (bsr_i),
        .ret_req    (ret_req),
        .reti_req   (reti_req),
        .retlit_req (retlit_req),
        .fast       (fast_i),
        .lit        (lit_i),
        .w_wr       (w_wr_o),
        .w_data     (w_data_o),
        .ctx_wr     (ctx_wr_o),
        .status_out (status_o),
        .bsr_out    (bsr_o),
        .gieh_set   (gieh_set_o),
        .giel_set   (giel_set_o)
    );
endmodule

// File: tb/tb_retstk_seq.sv
// Scoreboard bench: the driver predicts each cycle into a queue, the
// monitor compares the outputs one time unit after every rising edge.
module tb_retstk_seq;
    localparam int PC_W  = 21;
    localparam int DEPTH = 4;
    localparam int OFS_W = 11;
    localparam int CW    = $clog2(DEPTH+1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_vld_i = 1'b0;
    logic [2:0]        cmd_i = '0;
    logic [OFS_W-1:0]  ofs_i = '0;
    logic [7:0]        lit_i = '0;
    logic              fast_i = 1'b0;
    logic              irq_take_i = 1'b0;
    logic              irq_hi_i = 1'b0;
    logic [7:0]        w_i = '0;
    logic [7:0]        status_i = '0;
    logic [3:0]        bsr_i = '0;
    logic [PC_W-1:0]   pc_o;
    logic [PC_W-1:0]   tos_o;
    logic [CW-1:0]     depth_o;
    logic              ovf_o, unf_o, busy_o, w_wr_o, ctx_wr_o, gieh_set_o, giel_set_o;
    logic [7:0]        w_data_o, status_o;
    logic [3:0]        bsr_o;

    retstk_seq #(.PC_W(PC_W), .DEPTH(DEPTH), .OFS_W(OFS_W), .DATA_W(8), .BSR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i), .ofs_i(ofs_i),
        .lit_i(lit_i), .fast_i(fast_i), .irq_take_i(irq_take_i), .irq_hi_i(irq_hi_i),
        .w_i(w_i), .status_i(status_i), .bsr_i(bsr_i), .pc_o(pc_o), .tos_o(tos_o),
        .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o), .busy_o(busy_o),
        .w_wr_o(w_wr_o), .w_data_o(w_data_o), .ctx_wr_o(ctx_wr_o), .status_o(status_o),
        .bsr_o(bsr_o), .gieh_set_o(gieh_set_o), .giel_set_o(giel_set_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] tos;
        int              depth;
        bit              ovf, unf, busy, wwr, cwr, gh, gl;
        logic [7:0]      wdat, st;
        logic [3:0]      bsr;
        string           tag;
    } exp_t;

    exp_t            q[$];
    int              checks = 0;
    int              errors = 0;
    logic [PC_W-1:0] m_pc = '0;
    logic [PC_W-1:0] m_stk[$];
    bit              m_ovf = 0, m_unf = 0, m_busy = 0, m_shi = 0;
    logic [7:0]      m_sw = '0, m_sst = '0;
    logic [3:0]      m_sbsr = '0;

    // Model push and pop on the bench's own stack.
    task automatic m_push(input logic [PC_W-1:0] v);
        if (m_stk.size() == DEPTH) m_ovf = 1;
        else m_stk.push_back(v);
    endtask

    task automatic m_pop();
        if (m_stk.size() == 0) m_unf = 1;
        else void'(m_stk.pop_back());
    endtask

    // Drive one cycle of stimulus and queue the predicted outputs.
    task automatic step(input bit vld, input int c, input int ofs, input int lit, input bit fast,
                        input bit irq, input bit hi, input int w, input int st, input int b,
                        input string tag);
        exp_t e;
        logic [PC_W-1:0] top;
        bit was_busy;
        int so;
        @(negedge clk);
        cmd_vld_i = vld; cmd_i = 3'(c); ofs_i = OFS_W'(ofs); lit_i = 8'(lit); fast_i = fast;
        irq_take_i = irq; irq_hi_i = hi; w_i = 8'(w); status_i = 8'(st); bsr_i = 4'(b);
        e.wwr = 0; e.cwr = 0; e.gh = 0; e.gl = 0; e.wdat = '0; e.st = '0; e.bsr = '0;
        top = (m_stk.size() != 0) ? m_stk[m_stk.size()-1] : '0;
        was_busy = m_busy;
        m_busy = 0;
        if (vld && !was_busy) begin
            case (c)
                0: m_pc = m_pc + 2;
                1: begin m_push(m_pc + 2); m_pc = m_pc + 2; end
                2: begin m_pop(); m_pc = m_pc + 2; end
                3: begin
                    so = (ofs >= 1024) ? ofs - 2048 : ofs;
                    m_push(m_pc + 2);
                    m_pc = m_pc + PC_W'(2 + 2 * so);
                    m_busy = 1;
                end
                4, 5: begin
                    m_pop(); m_pc = top; m_busy = 1;
                    if (fast) begin
                        e.wwr = 1; e.wdat = m_sw; e.cwr = 1; e.st = m_sst; e.bsr = m_sbsr;
                    end
                    if (c == 5) begin e.gh = m_shi; e.gl = !m_shi; end
                end
                6: begin m_pop(); m_pc = top; m_busy = 1; e.wwr = 1; e.wdat = 8'(lit); end
                default: begin
                    m_pc = '0; m_stk.delete(); m_ovf = 0; m_unf = 0;
                    m_sw = '0; m_sst = '0; m_sbsr = '0; m_shi = 0;
                end
            endcase
        end
        if (irq && !(vld && !was_busy && c == 7)) begin
            m_sw = 8'(w); m_sst = 8'(st); m_sbsr = 4'(b); m_shi = hi;
        end
        e.pc = m_pc;
        e.tos = (m_stk.size() != 0) ? m_stk[m_stk.size()-1] : '0;
        e.depth = m_stk.size();
        e.ovf = m_ovf; e.unf = m_unf; e.busy = m_busy; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cmd(input int c, input int ofs, input int lit, input bit fast, input string tag);
        step(1, c, ofs, lit, fast, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Compare the outputs against the oldest prediction after each edge.
    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() != 0) begin
            e = q.pop_front();
            checks++;
            if (pc_o !== e.pc || tos_o !== e.tos || int'(depth_o) != e.depth ||
                ovf_o !== e.ovf || unf_o !== e.unf || busy_o !== e.busy ||
                w_wr_o !== e.wwr || w_data_o !== e.wdat || ctx_wr_o !== e.cwr ||
                status_o !== e.st || bsr_o !== e.bsr || gieh_set_o !== e.gh ||
                giel_set_o !== e.gl) begin
                errors++;
                $display("FAIL %s: pc %h/%h tos %h/%h depth %0d/%0d ovf %b/%b unf %b/%b busy %b/%b wwr %b/%b wdat %h/%h cwr %b/%b st %h/%h bsr %h/%h gh %b/%b gl %b/%b (actual/expected)",
                    e.tag, pc_o, e.pc, tos_o, e.tos, depth_o, e.depth, ovf_o, e.ovf, unf_o, e.unf,
                    busy_o, e.busy, w_wr_o, e.wwr, w_data_o, e.wdat, ctx_wr_o, e.cwr,
                    status_o, e.st, bsr_o, e.bsr, gieh_set_o, e.gh, giel_set_o, e.gl);
            end
        end
    end

    bit done = 0;

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pc_o !== '0 || tos_o !== '0 || depth_o !== '0 || ovf_o || unf_o || busy_o ||
            w_wr_o || ctx_wr_o || gieh_set_o || giel_set_o) begin
            errors++;
            $display("FAIL R1 reset: pc %h tos %h depth %0d busy %b (expected all zero)",
                     pc_o, tos_o, depth_o, busy_o);
        end
        rst_n = 1'b1;
        // R12: steps advance the PC.
        cmd(0, 0, 0, 0, "R12 step");
        cmd(0, 0, 0, 0, "R12 step");
        cmd(0, 0, 0, 0, "R12 step");
        // R4: forward call, then a push offered in the busy cycle (R8).
        cmd(3, 145, 0, 0, "R4 call forward");
        cmd(1, 0, 0, 0, "R8 push ignored while busy");
        // R2 and R3: push on top of the return address, then pop it.
        cmd(1, 0, 0, 0, "R2 push");
        cmd(2, 0, 0, 0, "R3 pop");
        // R5: plain return without restore.
        cmd(4, 0, 0, 0, "R5 return slow");
        idle("R5 busy cycle");
        // R13 capture, negative call, then interrupt return with restore (R6).
        step(0, 0, 0, 0, 0, 1, 1, 'hA5, 'h1C, 3, "R13 capture high");
        cmd(3, 'h7FD, 0, 0, "R4 call backward");
        idle("R4 busy cycle");
        cmd(5, 0, 0, 1, "R6 reti high fast");
        idle("R6 busy cycle");
        // R13 ordering: capture during a fast return uses the older copy.
        step(0, 0, 0, 0, 0, 1, 0, 'h5A, 'h03, 9, "R13 capture low");
        cmd(3, 2, 0, 0, "R4 call");
        idle("R4 busy cycle");
        step(1, 4, 0, 0, 1, 1, 1, 'hEE, 'hDD, 7, "R13 return fast with capture");
        idle("R5 busy cycle");
        cmd(3, 0, 0, 0, "R4 call");
        cmd(6, 0, 'h33, 0, "R8 literal return ignored while busy");
        cmd(5, 0, 0, 0, "R6 reti slow high");
        idle("R6 busy cycle");
        // R7: literal return.
        cmd(3, 'h400, 0, 0, "R4 call most negative");
        idle("R4 busy cycle");
        cmd(6, 0, 'h77, 1, "R7 literal return");
        idle("R7 busy cycle");
        // R9: fill and overflow the stack.
        for (int i = 0; i < DEPTH + 2; i++) cmd(1, 0, 0, 0, "R9 push to overflow");
        cmd(3, 5, 0, 0, "R9 call on full stack");
        idle("R9 busy cycle");
        // R11: software reset clears everything including the shadows.
        cmd(7, 0, 0, 0, "R11 software reset");
        cmd(3, 1, 0, 0, "R11 call after reset");
        idle("R11 busy cycle");
        cmd(5, 0, 0, 1, "R11 reti restores cleared shadows");
        idle("R11 busy cycle");
        // R10: underflow on pop and on return.
        cmd(2, 0, 0, 0, "R10 pop empty");
        cmd(0, 0, 0, 0, "R10 step");
        cmd(4, 0, 0, 0, "R10 return empty");
        idle("R10 busy cycle");
        idle("R10 flags sticky");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule